// File: doc/BRIEF.md
# Three-Phase Deadtime PWM Generator

This block drives the six gate signals of a three-leg inverter bridge. A symmetric triangular carrier runs between zero and a programmable peak. Each phase turns its signed reference into a compare value: the reference is scaled by a modulation index and centred on half the peak. That compare value decides when the leg is demanded high. For each phase, an enable bit can replace the modulated value with an explicit duty count. Each leg is then given a programmable deadtime, so that its upper and lower switches never conduct together.

Compare values and the carrier peak are taken only at the carrier valley, so a pulse is never cut short inside a carrier cycle. Each leg runs a four-state machine. LEG_LOW drives the lower switch. LEG_GAP_UP keeps both switches off before the upper one turns on. LEG_HIGH drives the upper switch. LEG_GAP_DN keeps both switches off before the lower one turns on. The transitions are:
- raise: LEG_LOW to LEG_GAP_UP, or straight to LEG_HIGH when the deadtime is zero.
- fall: LEG_HIGH to LEG_GAP_DN, or straight to LEG_LOW when the deadtime is zero.
- settle: from a gap state to its target side.
- abort: from a gap state back to the side it came from, when the demand reverts.

The carrier has two states, CAR_UP and CAR_DOWN, with two transitions. peak goes from CAR_UP to CAR_DOWN. valley goes from CAR_DOWN to CAR_UP. A motor drive with two motors uses two instances.

Top module: `tri_pwm_dt`

## Requirements
- R1: The carrier count starts at 0 after reset and steps by one each clock. It counts up to the peak P, then down to 1, then to 0 again, so one carrier cycle lasts 2P clocks. A peak input below 2 is used as 2.
- R2: The compare value of a phase that is not overridden is floor(P*(ref*m + 2^30)/2^31). Here ref is the phase's signed 16-bit reference, where 32767 is nearly +1.0. m is the modulation index, where 32768 means 1.0, and any larger value is used as 32768.
- R3: While bit i of the override enable is set (bit 0 = phase A, 1 = B, 2 = C), phase i takes its 16-bit override count as its compare value. The other phases keep their modulated values.
- R4: The peak, the compare values and the overrides are sampled only on the clock edge that ends a cycle in which the carrier count is 0. Changes at any other time have no effect until the next such edge.
- R5: A phase's demand is high in a cycle when the carrier count is below its compare value, or when the compare value is at least P. A compare value of 0 holds the leg low for the whole cycle, and one of P or more holds it high, with no glitch.
- R6: One clock after the demand rises, the lower gate goes low. The upper gate then goes high after D further clocks, where D is the deadtime input. A falling demand works the same way with the two gates swapped. If the demand reverts during the gap, the previous side turns back on one clock later.
- R7: The upper and lower gates of a leg are never high in the same cycle.
- R8: With a deadtime of 0, each lower gate is the exact complement of its upper gate from the cycle after.
- R9: During and directly after reset, every lower gate is high and every upper gate is low. The compare values are 0 and the peak is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | 16 | Carrier peak P in clocks |
| mod_i | input | 16 | Modulation index, 32768 = 1.0 |
| ref_i | input | 48 | Signed references, phase A in bits 15:0, B in 31:16, C in 47:32 |
| deadtime_i | input | 8 | Deadtime D in clocks |
| ovr_en_i | input | 3 | Per-phase override enable, bit 0 = A |
| ovr_val_i | input | 48 | Override compare counts, packed like ref_i |
| gate_hi_o | output | 3 | Upper gate per leg, bit 0 = A |
| gate_lo_o | output | 3 | Lower gate per leg, bit 0 = A |

## Verification
A setting applied in the valley cycle takes effect on that valley's edge, and the demand it produces is visible in the next cycle. The gates follow a demand change one clock later, and the far gate turns on D clocks after that. The bench keeps a cycle model that advances on the same edges as the design. It changes inputs and compares all six gates only at the falling edge, one full edge after the registers settle. Several peak, index, reference and deadtime combinations are swept, including overrides at 0 and at full scale and a mid-cycle change of the compare value.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
    typedef enum logic {
        CAR_UP,
        CAR_DOWN
    } car_dir_t;

    typedef enum logic [1:0] {
        LEG_LOW,
        LEG_GAP_UP,
        LEG_HIGH,
        LEG_GAP_DN
    } leg_state_t;
endpackage

// File: rtl/tpwm_carrier.sv
module tpwm_carrier
    import tpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] peak_o,
    output logic [CW-1:0] peak_next_o,
    output logic          valley_o
);
    localparam logic [CW-1:0] MIN_PEAK = CW'(2);

    car_dir_t      dir_q, dir_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] peak_q;

    assign peak_next_o = (period_i < MIN_PEAK) ? MIN_PEAK : period_i;
    assign valley_o    = (cnt_q == '0);
    assign cnt_o       = cnt_q;
    assign peak_o      = peak_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= CAR_UP;
            cnt_q  <= '0;
            peak_q <= MIN_PEAK;
        end else begin
            dir_q <= dir_n;
            cnt_q <= cnt_n;
            if (valley_o) peak_q <= peak_next_o;
        end
    end

    always_comb begin
        dir_n = dir_q;
        cnt_n = cnt_q;
        unique case (dir_q)
            CAR_UP: begin
                cnt_n = cnt_q + CW'(1);
                if ({1'b0, cnt_q} + (CW+1)'(1) >= {1'b0, peak_q}) dir_n = CAR_DOWN;
            end
            CAR_DOWN: begin
                cnt_n = cnt_q - CW'(1);
                if (cnt_q == CW'(1)) dir_n = CAR_UP;
            end
        endcase
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= peak_q);  // R1

    AST_CNT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q == $past(cnt_q) - CW'(1))));  // R1

    AST_PEAK_VALLEY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !valley_o |=> $stable(peak_q));  // R4
endmodule

// File: rtl/tpwm_duty.sv
module tpwm_duty #(
    parameter int CW = 16,
    parameter int RW = 16,
    parameter int MW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valley_i,
    input  logic [CW-1:0]        peak_next_i,
    input  logic signed [RW-1:0] ref_i,
    input  logic [MW-1:0]        mod_i,
    input  logic                 ovr_en_i,
    input  logic [CW-1:0]        ovr_val_i,
    output logic [CW-1:0]        duty_o
);
    localparam int              BW       = RW + MW - 1;
    localparam logic [MW-1:0]   UNITY    = MW'(1) << (MW - 1);
    localparam logic [BW-1:0]   HALF     = BW'(1) << (BW - 1);

    logic [MW-1:0]          mod_sat;
    logic signed [RW+MW:0]  prod;
    logic [BW-1:0]          biased;
    logic [CW+BW-1:0]       scaled;
    logic [CW-1:0]          duty_mod;
    logic [CW-1:0]          duty_q;

    always_comb begin
        mod_sat  = (mod_i > UNITY) ? UNITY : mod_i;
        prod     = ref_i * $signed({1'b0, mod_sat});
        biased   = prod[BW-1:0] + HALF;
        scaled   = {{BW{1'b0}}, peak_next_i} * {{CW{1'b0}}, biased};
        duty_mod = scaled[CW+BW-1:BW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        duty_q <= '0;
        else if (valley_i) duty_q <= ovr_en_i ? ovr_val_i : duty_mod;
    end

    assign duty_o = duty_q;

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valley_i |=> $stable(duty_q));  // R4

    AST_OVR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valley_i && ovr_en_i) |=> (duty_q == $past(ovr_val_i)));  // R3

    AST_MOD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (valley_i && !ovr_en_i) |=> (duty_q <= $past(peak_next_i)));  // R2
endmodule

// File: rtl/tpwm_deadband.sv
module tpwm_deadband
    import tpwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_i,
    input  logic [DW-1:0] dt_i,
    output logic          hi_o,
    output logic          lo_o
);
    leg_state_t    st_q, st_n;
    logic [DW-1:0] gap_q, gap_n;
    logic          dt_zero;

    assign dt_zero = (dt_i == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LEG_LOW;
            gap_q <= '0;
        end else begin
            st_q  <= st_n;
            gap_q <= gap_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        gap_n = gap_q;
        unique case (st_q)
            LEG_LOW: if (raw_i) begin
                st_n  = dt_zero ? LEG_HIGH : LEG_GAP_UP;
                gap_n = DW'(1);
            end
            LEG_GAP_UP: begin
                if (!raw_i)              st_n = LEG_LOW;
                else if (gap_q >= dt_i)  st_n = LEG_HIGH;
                else                     gap_n = gap_q + DW'(1);
            end
            LEG_HIGH: if (!raw_i) begin
                st_n  = dt_zero ? LEG_LOW : LEG_GAP_DN;
                gap_n = DW'(1);
            end
            LEG_GAP_DN: begin
                if (raw_i)               st_n = LEG_HIGH;
                else if (gap_q >= dt_i)  st_n = LEG_LOW;
                else                     gap_n = gap_q + DW'(1);
            end
        endcase
    end

    always_comb begin
        hi_o = 1'b0;
        lo_o = 1'b0;
        unique case (st_q)
            LEG_LOW:    lo_o = 1'b1;
            LEG_HIGH:   hi_o = 1'b1;
            LEG_GAP_UP,
            LEG_GAP_DN: ;
        endcase
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));  // R7

    AST_ZERO_DT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        dt_zero |=> (hi_o ^ lo_o));  // R8

    AST_LOWER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_o && raw_i) |=> !lo_o);  // R6
endmodule

// File: rtl/tri_pwm_dt.sv
module tri_pwm_dt #(
    parameter int CW  = 16,
    parameter int RW  = 16,
    parameter int MW  = 16,
    parameter int DW  = 8,
    parameter int NPH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     period_i,
    input  logic [MW-1:0]     mod_i,
    input  logic [NPH*RW-1:0] ref_i,
    input  logic [DW-1:0]     deadtime_i,
    input  logic [NPH-1:0]    ovr_en_i,
    input  logic [NPH*CW-1:0] ovr_val_i,
    output logic [NPH-1:0]    gate_hi_o,
    output logic [NPH-1:0]    gate_lo_o
);
    logic [CW-1:0] cnt, peak, peak_next;
    logic          valley;
    logic [CW-1:0] duty [NPH];
    logic [NPH-1:0] demand;

    tpwm_carrier #(.CW(CW)) u_carrier (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_i    (period_i),
        .cnt_o       (cnt),
        .peak_o      (peak),
        .peak_next_o (peak_next),
        .valley_o    (valley)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        tpwm_duty #(.CW(CW), .RW(RW), .MW(MW)) u_duty (
            .clk         (clk),
            .rst_n       (rst_n),
            .valley_i    (valley),
            .peak_next_i (peak_next),
            .ref_i       ($signed(ref_i[p*RW +: RW])),
            .mod_i       (mod_i),
            .ovr_en_i    (ovr_en_i[p]),
            .ovr_val_i   (ovr_val_i[p*CW +: CW]),
            .duty_o      (duty[p])
        );

        assign demand[p] = (duty[p] >= peak) || (cnt < duty[p]);

        tpwm_deadband #(.DW(DW)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (demand[p]),
            .dt_i  (deadtime_i),
            .hi_o  (gate_hi_o[p]),
            .lo_o  (gate_lo_o[p])
        );

        AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (duty[p] == '0) |-> !demand[p]);  // R5
        AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (duty[p] >= peak) |-> demand[p]);  // R5
    end
endmodule

// File: tb/tri_pwm_dt_test.sv
`timescale 1ns/1ps
module tri_pwm_dt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period_i = 16'd8;
    logic [15:0] mod_i = 16'd0;
    logic [47:0] ref_i = '0;
    logic [7:0]  deadtime_i = 8'd0;
    logic [2:0]  ovr_en_i = 3'b000;
    logic [47:0] ovr_val_i = '0;
    logic [2:0]  gate_hi_o, gate_lo_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tri_pwm_dt uut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .mod_i(mod_i),
        .ref_i(ref_i), .deadtime_i(deadtime_i), .ovr_en_i(ovr_en_i),
        .ovr_val_i(ovr_val_i), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
    );

    // cycle model built from the requirements
    longint m_cnt, m_per;
    bit     m_up;
    longint m_duty [3];
    int     m_st [3];   // 0 low, 1 gap up, 2 high, 3 gap down
    int     m_gap [3];

    function automatic longint calc_duty(longint per, int ph);
        longint r, m;
        if (ovr_en_i[ph]) return longint'(ovr_val_i[ph*16 +: 16]);
        r = longint'($signed(ref_i[ph*16 +: 16]));
        m = (mod_i > 16'd32768) ? 32768 : longint'(mod_i);
        return (per * (r * m + 64'sd1073741824)) / 64'sd2147483648;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_per = 2;
            for (int i = 0; i < 3; i++) begin m_duty[i] = 0; m_st[i] = 0; m_gap[i] = 0; end
        end else begin
            longint old_cnt, pn;
            bit raw;
            int dt;
            dt = int'(deadtime_i);
            for (int i = 0; i < 3; i++) begin
                raw = (m_duty[i] >= m_per) || (m_cnt < m_duty[i]);
                case (m_st[i])
                    0: if (raw) begin m_st[i] = (dt == 0) ? 2 : 1; m_gap[i] = 1; end
                    1: if (!raw) m_st[i] = 0; else if (m_gap[i] >= dt) m_st[i] = 2; else m_gap[i]++;
                    2: if (!raw) begin m_st[i] = (dt == 0) ? 0 : 3; m_gap[i] = 1; end
                    default: if (raw) m_st[i] = 2; else if (m_gap[i] >= dt) m_st[i] = 0; else m_gap[i]++;
                endcase
            end
            old_cnt = m_cnt;
            if (m_up) begin m_cnt++; if (m_cnt >= m_per) m_up = 0; end
            else begin m_cnt--; if (m_cnt == 0) m_up = 1; end
            if (old_cnt == 0) begin
                pn = (period_i < 16'd2) ? 2 : longint'(period_i);
                m_per = pn;
                for (int i = 0; i < 3; i++) m_duty[i] = calc_duty(pn, i);
            end
        end
    end

    task automatic check_cycle(string tag);
        logic [2:0] eh, el;
        for (int i = 0; i < 3; i++) begin
            eh[i] = (m_st[i] == 2);
            el[i] = (m_st[i] == 0);
        end
        checks++;
        if (gate_hi_o !== eh || gate_lo_o !== el) begin
            errors++;
            $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b (t=%0t)", tag, gate_hi_o, gate_lo_o, eh, el, $time);
        end
        checks++;
        if ((gate_hi_o & gate_lo_o) !== 3'b000) begin
            errors++;
            $display("FAIL R7: overlap hi=%b lo=%b expected no common bit", gate_hi_o, gate_lo_o);
        end
    endtask

    task automatic run(int n, string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_cycle(tag);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        check_cycle("R9 reset");
        rst_n = 1'b1;
        run(2, "R9 after reset");

        // main modulation with deadtime
        period_i = 16'd8; mod_i = 16'd32768; deadtime_i = 8'd2;
        ref_i = {16'sd20000, -16'sd28000, 16'sd12000};
        run(60, "R2 R6 modulated");

        // index above unity saturates
        mod_i = 16'd50000;
        run(40, "R2 saturated index");

        // overrides: A at 0, C at full, B modulated
        ovr_en_i = 3'b101; ovr_val_i = {16'd8, 16'd3, 16'd0};
        run(60, "R3 R5 override");

        // mid-cycle change must wait for valley
        ovr_en_i = 3'b000; ref_i = 48'd0; mod_i = 16'd16384;
        run(5, "R4 setup");
        ref_i = {16'sd32767, 16'sd32767, -16'sd32768};
        run(40, "R4 mid-cycle change");

        // zero deadtime complements
        deadtime_i = 8'd0;
        run(50, "R8 zero deadtime");

        // peak below minimum
        period_i = 16'd1;
        run(30, "R1 small peak");

        // near-exhaustive sweep
        for (int p = 0; p < 4; p++) begin
            for (int mi = 0; mi < 4; mi++) begin
                for (int d = 0; d < 3; d++) begin
                    int pv [4] = '{2, 3, 5, 9};
                    int mv [4] = '{0, 16384, 32768, 40000};
                    int dv [3] = '{0, 1, 3};
                    period_i = 16'(pv[p]); mod_i = 16'(mv[mi]); deadtime_i = 8'(dv[d]);
                    ref_i = {16'(p * 9000 - 15000), 16'(-mi * 7000), 16'(d * 11000 + 1)};
                    ovr_en_i = 3'((p + mi + d) % 8);
                    ovr_val_i = {16'(pv[p]), 16'(d), 16'(mi)};
                    run(4 * pv[p] + 8, "R1 R2 R3 R5 R6 sweep");
                end
            end
        end
        done = 1;
        summary();
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            summary();
        end
    end
endmodule